// File: doc/BRIEF.md
# Exhaustive Stuck-At Fault Scanner

This block applies every 3-bit input pattern, one per clock, to a small combinational circuit. Each pattern goes to three copies of the circuit: one with no fault and two that each carry a fault chosen by a select code. For every pattern the block raises a detect flag when the first faulty copy disagrees with the fault-free copy. It raises a distinguish flag when the two faulty copies disagree with each other. Over the scan it counts the patterns that detect the first fault. Comparing that count with zero tells the user whether the fault is detectable at all, and this is the per-fault input to a coverage figure (faults detected over faults tried, never above 1).

Two circuits can be selected. The single-output circuit is a NAND of two NANDs, NAND(x1,x2) and NAND(x2,x3), and it reduces to x2·(x1+x3). The two-output circuit gives Z1 = x1·x2 and Z2 = x2·x3. In both, the pattern is read as x1x2x3 with x1 in the most significant bit. A scan begins on a start pulse, which also samples the fault codes and the circuit choice. The scan runs from 000 up to 111 and ends with a one-cycle done pulse.

Top module: `fault_scan`

## Requirements
- R1: After reset, vecValid, detect, distinguish and done are 0 and detectCount is 0.
- R2: A start pulse sampled on a clock edge makes vecValid 1 from that edge on, with vecOut = 000. vecOut then rises by one per clock in ascending binary order up to 111.
- R3: On the edge after the cycle showing 111, done is 1 for exactly one cycle and vecValid returns to 0.
- R4: With dualMode 0 the circuit output is x2·(x1+x3), where x1 = vecOut[2], x2 = vecOut[1] and x3 = vecOut[0]. Fault code 0 is fault-free, so faultSelA = 0 never raises detect.
- R5: While vecValid is 1, detect is 1 exactly when the output of the faultSelA copy differs from the fault-free output at vecOut. The codes are: 1 x1 stuck-at-0, 2 x1 stuck-at-1, 3 x2 stuck-at-0, 4 x2 stuck-at-1, 5 x3 stuck-at-0, 6 x3 stuck-at-1, 7 OR-bridge of x1 and x2 (both lines take x1+x2).
- R6: While vecValid is 1, distinguish is 1 exactly when the faultSelA copy and the faultSelB copy give different outputs. For x2 stuck-at-1 against x3 stuck-at-0, pattern 101 both detects and distinguishes.
- R7: With dualMode 1 the outputs are Z1 = x1·x2 and Z2 = x2·x3. A pattern detects or distinguishes when either output differs. Under the bridge, pattern 011 gives 01 fault-free and 11 faulty.
- R8: detectCount is the number of patterns of the current scan that raised detect. It saturates at 8, is cleared by start, and holds its value after done.
- R9: faultSelA, faultSelB and dualMode are sampled only on the start edge. Changing them during a scan has no effect on that scan.
- R10: A start pulse during a scan restarts it from 000 with detectCount cleared and the new fault codes in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin (or restart) a scan; samples selects |
| dualMode | input | 1 | 0: single-output NAND circuit, 1: two-output AND pair |
| faultSelA | input | 3 | Fault code of the detect copy |
| faultSelB | input | 3 | Fault code of the second faulty copy |
| vecOut | output | 3 | Current pattern x1x2x3 |
| vecValid | output | 1 | A scan pattern is being shown |
| detect | output | 1 | Current pattern detects fault A |
| distinguish | output | 1 | Current pattern tells fault A from fault B |
| done | output | 1 | One-cycle pulse after the last pattern |
| detectCount | output | 4 | Detecting patterns in the scan so far |

## Verification
The hardest situation to reach from the ports is a scan that has to ignore its select inputs while it runs (R9), or that is cut short by a second start (R10). After every randomly drawn scan has begun, the bench scrambles the selects and the mode. It still expects the results of the sampled values. A directed sequence pulses start again in the middle of a scan with different codes and follows the scan from 000. Random fault pairs in both modes are combined with the known cases 101 and 011.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int NUM_IN  = 3;
  localparam int NUM_VEC = 1 << NUM_IN;
  localparam int CODE_W  = 3;
  localparam int OUT_W   = 2;
  localparam int CNT_W   = $clog2(NUM_VEC + 1);
  localparam int NUM_COPY = 3;

  typedef enum logic [CODE_W-1:0] {
    FLT_NONE   = 3'd0,
    FLT_A_SA0  = 3'd1,
    FLT_A_SA1  = 3'd2,
    FLT_B_SA0  = 3'd3,
    FLT_B_SA1  = 3'd4,
    FLT_C_SA0  = 3'd5,
    FLT_C_SA1  = 3'd6,
    FLT_BRIDGE = 3'd7
  } faultT;

  typedef struct packed {
    logic clear;   // load selects, zero pattern and count
    logic step;    // accumulate and advance
    logic active;  // a pattern is being shown
  } strobeT;

  // Evaluate the selected circuit with one fault injected on its inputs.
  function automatic logic [OUT_W-1:0] evalCircuit(input logic [NUM_IN-1:0] vec,
                                                    input faultT code,
                                                    input logic dual);
    logic lineA, lineB, lineC, nandAB, nandBC, orAB;
    logic [OUT_W-1:0] res;
    lineA = vec[2];
    lineB = vec[1];
    lineC = vec[0];
    orAB  = lineA | lineB;
    case (code)
      FLT_A_SA0:  lineA = 1'b0;
      FLT_A_SA1:  lineA = 1'b1;
      FLT_B_SA0:  lineB = 1'b0;
      FLT_B_SA1:  lineB = 1'b1;
      FLT_C_SA0:  lineC = 1'b0;
      FLT_C_SA1:  lineC = 1'b1;
      FLT_BRIDGE: begin
        lineA = orAB;
        lineB = orAB;
      end
      default: ;
    endcase
    nandAB = ~(lineA & lineB);
    nandBC = ~(lineB & lineC);
    if (dual) res = {lineA & lineB, lineB & lineC};
    else      res = {1'b0, ~(nandAB & nandBC)};
    return res;
  endfunction
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   lastVec,
  output strobeT strobe,
  output logic   valid,
  output logic   done
);
  typedef enum logic {ST_IDLE, ST_RUN} stateT;
  stateT stateQ;
  logic  doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else if (start) begin
      stateQ <= ST_RUN;
      doneQ  <= 1'b0;
    end else if (stateQ == ST_RUN && lastVec) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b1;
    end else begin
      doneQ  <= 1'b0;
    end
  end

  always_comb begin
    strobe.clear  = start;
    strobe.step   = (stateQ == ST_RUN) && !start;
    strobe.active = (stateQ == ST_RUN);
  end

  assign valid = (stateQ == ST_RUN);
  assign done  = doneQ;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R3
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    start |=> valid); // R2
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !valid); // R3
endmodule

// File: rtl/scan_dp.sv
module scan_dp
  import scan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [CODE_W-1:0] faultAIn,
  input  logic [CODE_W-1:0] faultBIn,
  input  logic              dualIn,
  output logic [NUM_IN-1:0] vec,
  output logic              lastVec,
  output logic              detect,
  output logic              distinct,
  output logic [CNT_W-1:0]  count
);
  logic [NUM_IN-1:0] vecQ;
  logic [CNT_W-1:0]  cntQ;
  faultT             faultAQ, faultBQ;
  logic              dualQ;
  faultT             copyCode [NUM_COPY];
  logic [OUT_W-1:0]  copyOut  [NUM_COPY];
  logic              rawDetect, rawDistinct;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecQ    <= '0;
      cntQ    <= '0;
      faultAQ <= FLT_NONE;
      faultBQ <= FLT_NONE;
      dualQ   <= 1'b0;
    end else if (strobe.clear) begin
      vecQ    <= '0;
      cntQ    <= '0;
      faultAQ <= faultT'(faultAIn);
      faultBQ <= faultT'(faultBIn);
      dualQ   <= dualIn;
    end else if (strobe.step) begin
      vecQ <= vecQ + 1'b1;
      if (rawDetect && cntQ != CNT_W'(NUM_VEC)) cntQ <= cntQ + 1'b1;
    end
  end

  always_comb begin
    copyCode[0] = FLT_NONE;
    copyCode[1] = faultAQ;
    copyCode[2] = faultBQ;
  end

  for (genvar g = 0; g < NUM_COPY; g++) begin : g_copy
    assign copyOut[g] = evalCircuit(vecQ, copyCode[g], dualQ);
  end

  assign rawDetect   = |(copyOut[1] ^ copyOut[0]);
  assign rawDistinct = |(copyOut[1] ^ copyOut[2]);
  assign detect   = strobe.active & rawDetect;
  assign distinct = strobe.active & rawDistinct;
  assign vec      = vecQ;
  assign lastVec  = (vecQ == NUM_IN'(NUM_VEC - 1));
  assign count    = cntQ;

  AST_VEC_ASCENDS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !lastVec) |=> vec == $past(vec) + 1'b1); // R2
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(NUM_VEC)); // R8
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (count == '0 && vec == '0)); // R10
  AST_NOFAULT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (faultAQ == FLT_NONE) |-> !detect); // R4
  AST_SAME_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    (faultAQ == faultBQ) |-> !distinct); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.step && !strobe.clear) |=> $stable(count)); // R8
endmodule

// File: rtl/fault_scan.sv
module fault_scan
  import scan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              dualMode,
  input  logic [CODE_W-1:0] faultSelA,
  input  logic [CODE_W-1:0] faultSelB,
  output logic [NUM_IN-1:0] vecOut,
  output logic              vecValid,
  output logic              detect,
  output logic              distinguish,
  output logic              done,
  output logic [CNT_W-1:0]  detectCount
);
  strobeT strobe;
  logic   lastVec;

  scan_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .lastVec (lastVec),
    .strobe  (strobe),
    .valid   (vecValid),
    .done    (done)
  );

  scan_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .faultAIn (faultSelA),
    .faultBIn (faultSelB),
    .dualIn   (dualMode),
    .vec      (vecOut),
    .lastVec  (lastVec),
    .detect   (detect),
    .distinct (distinguish),
    .count    (detectCount)
  );
endmodule

// File: tb/fault_scan_bench.sv
`timescale 1ns/1ps
module fault_scan_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       dualMode = 1'b0;
  logic [2:0] faultSelA = 3'd0;
  logic [2:0] faultSelB = 3'd0;
  logic [2:0] vecOut;
  logic       vecValid, detect, distinguish, done;
  logic [3:0] detectCount;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fault_scan u_fault_scan (
    .clk(clk), .rstN(rstN), .start(start), .dualMode(dualMode),
    .faultSelA(faultSelA), .faultSelB(faultSelB), .vecOut(vecOut),
    .vecValid(vecValid), .detect(detect), .distinguish(distinguish),
    .done(done), .detectCount(detectCount)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model built from the requirement text.
  function automatic int refOut(input int v, input int code, input bit dual);
    bit p1, p2, p3;
    p1 = v[2]; p2 = v[1]; p3 = v[0];
    if (code == 1) p1 = 0;
    if (code == 2) p1 = 1;
    if (code == 3) p2 = 0;
    if (code == 4) p2 = 1;
    if (code == 5) p3 = 0;
    if (code == 6) p3 = 1;
    if (code == 7) begin
      p1 = v[2] | v[1];
      p2 = p1;
    end
    if (dual) return (p1 && p2 ? 2 : 0) + (p2 && p3 ? 1 : 0);
    return (p2 && (p1 || p3)) ? 1 : 0;
  endfunction

  // One full scan; scramble alters the selects after start (R9).
  task automatic runScan(input int fa, input int fb, input bit dual, input bit scramble);
    int expCnt = 0;
    @(negedge clk);
    faultSelA = 3'(fa); faultSelB = 3'(fb); dualMode = dual; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (scramble) begin
      faultSelA = 3'($urandom_range(0, 7));
      faultSelB = 3'($urandom_range(0, 7));
      dualMode  = ~dual;
    end
    for (int i = 0; i < 8; i++) begin
      bit expDet, expDis;
      expDet = refOut(i, fa, dual) != refOut(i, 0, dual);
      expDis = refOut(i, fa, dual) != refOut(i, fb, dual);
      check("R2 vecValid", vecValid, 1);
      check("R2 vecOut", vecOut, i);
      check(dual ? "R7/R9 detect" : "R5/R9 detect", detect, expDet);
      check(dual ? "R7/R9 distinguish" : "R6/R9 distinguish", distinguish, expDis);
      check("R8 running count", detectCount, expCnt);
      if (expDet && expCnt < 8) expCnt++;
      @(negedge clk);
    end
    check("R3 done", done, 1);
    check("R3 vecValid low", vecValid, 0);
    check("R8 final count", detectCount, expCnt);
    @(negedge clk);
    check("R3 done single", done, 0);
    check("R8 count held", detectCount, expCnt);
  endtask

  initial begin
    void'($urandom(32'd4211));
    repeat (3) @(negedge clk);
    check("R1 vecValid", vecValid, 0);
    check("R1 done", done, 0);
    check("R1 detect", detect, 0);
    check("R1 distinguish", distinguish, 0);
    check("R1 count", detectCount, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", vecValid, 0);

    // R6: x2 sa1 against x3 sa0; 101 detects and distinguishes
    runScan(4, 5, 1'b0, 1'b0);
    // R4: fault-free selection never detects
    runScan(0, 3, 1'b0, 1'b0);
    // R5: x2 sa1 detected by 001, 100, 101 -> count 3
    @(negedge clk);
    faultSelA = 3'd4; faultSelB = 3'd0; dualMode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    check("R5 x2 sa1 count", detectCount, 3);
    // R7: bridge in dual mode at 011
    runScan(7, 0, 1'b1, 1'b0);
    @(negedge clk);
    faultSelA = 3'd7; faultSelB = 3'd0; dualMode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 vec 011", vecOut, 3);
    check("R7 bridge detect at 011", detect, 1);
    // R10: restart mid-scan with new codes
    start = 1'b1; faultSelA = 3'd2; faultSelB = 3'd6; dualMode = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check("R10 restart vec", vecOut, 0);
    check("R10 restart count", detectCount, 0);
    check("R10 restart valid", vecValid, 1);
    repeat (9) @(negedge clk);
    check("R10 new-code count", detectCount, 1);

    for (int n = 0; n < 40; n++)
      runScan($urandom_range(0, 7), $urandom_range(0, 7), 1'($urandom_range(0, 1)), 1'b1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule